// File: doc/BRIEF.md
# Prescaled Reload Interval Timer

This block produces a periodic interrupt for a small controller. The system clock is first reduced to an instruction-rate enable that fires once every three system clocks. A prescaler counts those enables and divides them by 4 or by 16. Each prescaled tick steps an 8-bit down-counter. When the counter has reached zero, the next tick reloads it from a reload register and marks an expiry. Because of this, one period spans (reload + 1) prescaled ticks.

Each expiry latches a request flag. The flag stays set until software runs a test-and-clear on it. The interrupt line is the flag gated by a per-timer enable and by a global enable. Software controls three things through a control register: the counter's run bit, the prescaler's run bit and the divide select. It can also write the reload value and the two enable bits.

With a 4.0 MHz system clock, divide-by-16 and a reload of 82, the period is 3·16·83 = 3984 system clocks, which is close to 1 ms.

Top module: `prescaled_reload_timer`

## Requirements
- R1: After reset the counter, reload register, control bits, both enables and the request flag are all 0, so `count_o`, `flag_o`, `irq_o` and `tac_hit_o` read 0.
- R2: The prescaler advances only on the instruction-rate enable, which occurs once every 3 system clocks. With divide-by-4 and a reload of N, consecutive expiries are 12·(N+1) system clocks apart.
- R3: Control bit 2 selects the prescale ratio: 0 gives divide-by-4 and 1 gives divide-by-16. With divide-by-16 and a reload of N, expiries are 48·(N+1) system clocks apart.
- R4: On a tick with the counter at 0, the counter reloads from the reload register in that same tick. Every period is therefore exactly (reload+1) ticks long, with no drift between periods.
- R5: Control bit 0 runs the counter and control bit 1 runs the prescaler. When the counter is stopped, `count_o` holds its value. When the prescaler is stopped, its internal count returns to 0.
- R6: A reload write (`rld_we`) always updates the reload register. When the counter is stopped, the same write also loads the counter. When the counter is running, the counter is not affected until its next reload.
- R7: An expiry sets the request flag, and the flag stays set until it is cleared by a test-and-clear.
- R8: `irq_o` is 1 exactly when the flag, the per-timer enable and the global enable are all 1.
- R9: In the cycle where `tac_req` is high, `tac_hit_o` shows the current flag value, and the flag is cleared at the next edge. If an expiry happens in that same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Bit0 counter run, bit1 prescaler run, bit2 divide select (1 = /16) |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | CNT_W | Reload value |
| en_we | input | 1 | Per-timer enable write strobe |
| en_wdata | input | 1 | Per-timer enable value |
| gie_we | input | 1 | Global enable write strobe |
| gie_wdata | input | 1 | Global enable value |
| tac_req | input | 1 | Test-and-clear request for the flag |
| tac_hit_o | output | 1 | Flag value reported during test-and-clear |
| count_o | output | CNT_W | Current counter value |
| flag_o | output | 1 | Latched request flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
Some internal faults are visible directly. A broken instruction-rate divider or a prescaler that counts to the wrong limit does not corrupt `count_o` right away. It moves the next counter step, so the mismatch appears within 3 to 48 clocks of the fault. A reload that takes the wrong value, or that happens one tick late, shows up at the first expiry as a wrong `count_o` and a period of the wrong length. A flag that loses a collision with a clear shows up on `flag_o` in the next cycle. Faults in the enable gating show up on `irq_o` in the same cycle in which the flag or an enable changes.

// File: rtl/timer_pkg.sv
package timer_pkg;
    // Control register layout: bit0 counter run, bit1 prescaler run, bit2 divide select
    typedef struct packed {
        logic pre_sel;
        logic pre_run;
        logic tmr_run;
    } ctl_t;
endpackage

// File: rtl/instr_clk_gen.sv
module instr_clk_gen #(
    parameter int DIV = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic ie_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) st_d.cnt = '0;
        else                  st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ie_o = (st_q.cnt == LAST);
endmodule

// File: rtl/prescaler.sv
module prescaler #(
    parameter int RATIO_LO = 4,
    parameter int RATIO_HI = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ie_i,
    input  logic run_i,
    input  logic sel_i,
    output logic tick_o
);
    localparam int W = $clog2(RATIO_HI);
    localparam logic [W-1:0] LIM_LO = W'(RATIO_LO - 1);
    localparam logic [W-1:0] LIM_HI = W'(RATIO_HI - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] lim;
    logic         wrap;

    always_comb begin
        lim  = sel_i ? LIM_HI : LIM_LO;
        wrap = (st_q.cnt >= lim);
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (ie_i) begin
            st_d.cnt = wrap ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = run_i & ie_i & wrap;
endmodule

// File: rtl/reload_counter.sv
module reload_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         run_i,
    input  logic         ld_i,
    input  logic [W-1:0] ld_val_i,
    input  logic [W-1:0] reload_i,
    output logic [W-1:0] count_o,
    output logic         expire_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic at_zero;

    always_comb begin
        at_zero = (st_q.cnt == '0);
        st_d    = st_q;
        if (run_i) begin
            if (tick_i) st_d.cnt = at_zero ? reload_i : st_q.cnt - 1'b1;
        end else if (ld_i) begin
            st_d.cnt = ld_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o  = st_q.cnt;
    assign expire_o = run_i & tick_i & at_zero;
endmodule

// File: rtl/prescaled_reload_timer.sv
module prescaled_reload_timer #(
    parameter int CNT_W    = 8,
    parameter int SYS_DIV  = 3,
    parameter int RATIO_LO = 4,
    parameter int RATIO_HI = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [2:0]       ctl_wdata,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] rld_wdata,
    input  logic             en_we,
    input  logic             en_wdata,
    input  logic             gie_we,
    input  logic             gie_wdata,
    input  logic             tac_req,
    output logic             tac_hit_o,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             irq_o
);
    import timer_pkg::*;

    typedef struct packed {
        ctl_t             ctl;
        logic             en;
        logic             gie;
        logic [CNT_W-1:0] rld;
        logic             flag;
    } st_t;

    st_t  st_d, st_q;
    logic ie;
    logic tick;
    logic expire;

    instr_clk_gen #(.DIV(SYS_DIV)) u_iclk (
        .clk   (clk),
        .rst_n (rst_n),
        .ie_o  (ie)
    );

    prescaler #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .ie_i   (ie),
        .run_i  (st_q.ctl.pre_run),
        .sel_i  (st_q.ctl.pre_sel),
        .tick_o (tick)
    );

    reload_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .run_i    (st_q.ctl.tmr_run),
        .ld_i     (rld_we),
        .ld_val_i (rld_wdata),
        .reload_i (st_q.rld),
        .count_o  (count_o),
        .expire_o (expire)
    );

    always_comb begin
        st_d = st_q;
        if (ctl_we) st_d.ctl = ctl_t'(ctl_wdata);
        if (en_we)  st_d.en  = en_wdata;
        if (gie_we) st_d.gie = gie_wdata;
        if (rld_we) st_d.rld = rld_wdata;
        if (expire)       st_d.flag = 1'b1;
        else if (tac_req) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o    = st_q.flag;
    assign tac_hit_o = st_q.flag;
    assign irq_o     = st_q.flag & st_q.en & st_q.gie;
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ie,
    input logic         tick,
    input logic         expire,
    input logic         tmr_run,
    input logic         rld_we,
    input logic         tac_req,
    input logic [W-1:0] rld_q,
    input logic [W-1:0] count_o,
    input logic         flag_o,
    input logic         irq_o
);
    AST_IE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        ie |=> !ie); // R2
    AST_TICK_ON_IE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> ie); // R3
    AST_RELOAD_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count_o == $past(rld_q))); // R4
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_run && !rld_we) |=> $stable(count_o)); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !tac_req) |=> flag_o); // R7
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o); // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tac_req && !expire) |=> !flag_o); // R9
    AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag_o); // R9
endmodule

bind prescaled_reload_timer timer_checker #(.W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ie      (ie),
    .tick    (tick),
    .expire  (expire),
    .tmr_run (st_q.ctl.tmr_run),
    .rld_we  (rld_we),
    .tac_req (tac_req),
    .rld_q   (st_q.rld),
    .count_o (count_o),
    .flag_o  (flag_o),
    .irq_o   (irq_o)
);

// File: tb/test_prescaled_reload_timer.sv
module test_prescaled_reload_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_we = 1'b0;
    logic [2:0]    ctl_wdata = '0;
    logic          rld_we = 1'b0;
    logic [CW-1:0] rld_wdata = '0;
    logic          en_we = 1'b0, en_wdata = 1'b0;
    logic          gie_we = 1'b0, gie_wdata = 1'b0;
    logic          tac_req = 1'b0;
    logic          tac_hit_o, flag_o, irq_o;
    logic [CW-1:0] count_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural reference state
    int m_d3, m_pre, m_cnt, m_rld;
    bit m_trun, m_prun, m_sel, m_en, m_gie, m_flag;

    prescaled_reload_timer i_prescaled_reload_timer (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .rld_we(rld_we), .rld_wdata(rld_wdata), .en_we(en_we), .en_wdata(en_wdata),
        .gie_we(gie_we), .gie_wdata(gie_wdata), .tac_req(tac_req),
        .tac_hit_o(tac_hit_o), .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // reference model: advanced on each rising edge from the values before it
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_d3 = 0; m_pre = 0; m_cnt = 0; m_rld = 0;
            m_trun = 0; m_prun = 0; m_sel = 0; m_en = 0; m_gie = 0; m_flag = 0;
        end else begin
            bit ie, tk, ex;
            int ratio;
            ratio = m_sel ? 16 : 4;
            ie = (m_d3 == 2);
            m_d3 = (m_d3 + 1) % 3;
            tk = m_prun && ie && (m_pre == ratio - 1);
            if (!m_prun) m_pre = 0;
            else if (ie) m_pre = (m_pre == ratio - 1) ? 0 : m_pre + 1;
            ex = m_trun && tk && (m_cnt == 0);
            if (m_trun) begin
                if (tk) m_cnt = (m_cnt == 0) ? m_rld : m_cnt - 1;
            end else if (rld_we) m_cnt = int'(rld_wdata);
            if (rld_we) m_rld = int'(rld_wdata);
            if (ex) m_flag = 1;
            else if (tac_req) m_flag = 0;
            if (ctl_we) begin
                m_trun = ctl_wdata[0]; m_prun = ctl_wdata[1]; m_sel = ctl_wdata[2];
            end
            if (en_we)  m_en  = en_wdata;
            if (gie_we) m_gie = gie_wdata;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R4 count", int'(count_o), m_cnt);
            chk("R7 flag", int'(flag_o), int'(m_flag));
            chk("R8 irq", int'(irq_o), int'(m_flag && m_en && m_gie));
            chk("R9 hit", int'(tac_hit_o), int'(m_flag));
        end
    end

    task automatic step(); @(negedge clk); endtask

    task automatic wr_ctl(input logic [2:0] v);
        ctl_we = 1'b1; ctl_wdata = v; step(); ctl_we = 1'b0;
    endtask

    task automatic wr_rld(input int v);
        rld_we = 1'b1; rld_wdata = CW'(v); step(); rld_we = 1'b0;
    endtask

    task automatic rise_and_clear(output int t);
        t = -1;
        for (int i = 0; i < 3000; i++) begin
            if (flag_o) begin t = cyc; break; end
            step();
        end
        tac_req = 1'b1; step(); tac_req = 1'b0;
    endtask

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        int t1, t2, t3, held, hi_cnt;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 count", int'(count_o), 0);
        chk("R1 flag", int'(flag_o), 0);
        chk("R1 irq", int'(irq_o), 0);
        chk("R1 hit", int'(tac_hit_o), 0);

        wr_rld(2);
        chk("R6 load when stopped", int'(count_o), 2);

        wr_ctl(3'b011); // divide-by-4, both running
        rise_and_clear(t1);
        rise_and_clear(t2);
        rise_and_clear(t3);
        chk("R2 period /4 reload 2", t2 - t1, 36);
        chk("R4 no drift", t3 - t2, 36);

        wr_rld(1); // running: only the reload register changes (R6)
        wr_ctl(3'b111); // divide-by-16
        rise_and_clear(t1);
        rise_and_clear(t1);
        rise_and_clear(t2);
        chk("R3 period /16 reload 1", t2 - t1, 96);

        wr_ctl(3'b110); // counter stopped, prescaler running
        held = int'(count_o);
        repeat (40) step();
        chk("R5 hold when stopped", int'(count_o), held);
        wr_rld(5);
        chk("R6 load when stopped", int'(count_o), 5);
        wr_ctl(3'b100); // prescaler stopped too, its count clears
        repeat (7) step();
        wr_ctl(3'b111);
        rise_and_clear(t1);
        rise_and_clear(t2);
        chk("R5 period after restart", t2 - t1, 288);

        en_we = 1'b1; en_wdata = 1'b1; step(); en_we = 1'b0;
        for (int i = 0; i < 400 && !flag_o; i++) step();
        chk("R8 irq without global", int'(irq_o), 0);
        gie_we = 1'b1; gie_wdata = 1'b1; step(); gie_we = 1'b0;
        chk("R8 irq all set", int'(irq_o), 1);
        en_we = 1'b1; en_wdata = 1'b0; step(); en_we = 1'b0;
        chk("R8 irq enable off", int'(irq_o), 0);
        en_we = 1'b1; en_wdata = 1'b1; step(); en_we = 1'b0;

        repeat (300) step();
        chk("R7 flag sticky", int'(flag_o), 1);

        tac_req = 1'b1;
        chk("R9 hit reports set", int'(tac_hit_o), 1);
        step();
        tac_req = 1'b0;
        chk("R9 cleared", int'(flag_o), 0);

        // hold clear: flag only visible in the cycle right after each expiry
        for (int i = 0; i < 400 && !flag_o; i++) step();
        tac_req = 1'b1;
        hi_cnt = 0;
        for (int i = 0; i < 576; i++) begin
            step();
            if (flag_o) hi_cnt++;
        end
        tac_req = 1'b0;
        chk("R9 expiry wins over clear", hi_cnt, 2);

        step();
        summary();
    end
endmodule